// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection

A bank of up to 32 general-purpose lines behind a small memory-mapped register interface with single-cycle read and write strobes. Each line is either a general input, a general output, or an interrupt input. Interrupt inputs sense a level or an edge. The active sense is chosen per line as high/rising or low/falling, and edge lines can also trigger on both edges. Edge events stay latched until software clears them. Level events follow the pin. All pending, unmasked events are combined into one interrupt output.

Pins are passed through a two-flop synchronizer before any use. Software reads the input-data register to see the pins, and lines driven as outputs read back the value being driven. The register interface carries no data stream, so it has no valid/ready handshake: a write takes effect at the clock edge where `reg_wr` is high, and `reg_rdata` is valid in the same cycle as `reg_rd`. Back-pressure does not apply.

Top module: `gpio_irq_bank`

## Requirements
- R1: After a synchronous reset (`rst_n` low), every register reads 0, so every line is a general input, `pin_oe` is 0 and `irq_out` is 0. `reg_rdata` is 0 whenever `reg_rd` is low.
- R2: `pin_out` equals the output-data register (offset 0x08). A bit of `pin_oe` is 1 only when that line's direction bit (offset 0x04, 1 = output) is 1 and its mode bit (offset 0x00, 1 = interrupt input, 0 = general) is 0.
- R3: A read of offset 0x0C returns the output-data bit on lines that are general outputs. On every other line it returns the pin value, delayed by two clock edges.
- R4: A line in interrupt mode with sense bit 0 (offset 0x24; 1 = edge, 0 = level) has a status bit (offset 0x10) that equals the synchronized pin XOR its polarity bit (offset 0x20; 1 = active low). The status bit updates one edge after synchronization. A general-mode line always has status 0.
- R5: An edge-sensing line with polarity 0 sets its status on a rising synchronized edge, and with polarity 1 on a falling one. The bit stays set until it is cleared.
- R6: An edge-sensing line whose both-edge bit (offset 0x4C) is 1 sets its status on either edge, whatever its polarity bit.
- R7: Writing offset 0x14 clears the latched status of every line written as 1 and leaves lines written as 0 alone. If an edge arrives in the same cycle as the clear, the status stays set.
- R8: Writing offset 0x18 clears every mask bit written as 0 and keeps the bits written as 1. Writing offset 0x1C sets every mask bit written as 1. A read of 0x18 returns the mask, where 1 = enabled.
- R9: `irq_out` is 1 exactly when some line has both its status bit and its mask bit set.
- R10: Writes to 0x0C and 0x10 have no effect. Reads of 0x14, 0x1C and any unlisted offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data, one bit per line |
| reg_rdata | output | 32 | Read data, valid while reg_rd is high |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Driven pin values |
| pin_oe | output | 32 | Per-line output enable |
| irq_out | output | 1 | Combined interrupt |

## Verification
The bench drives the pins through several kinds of traffic: static levels under both polarities, single rising and falling pulses on single-edge lines, back-to-back toggles on a both-edge line, and a clear that lands in the same cycle as a new edge. Level traffic separates level sensing from edge latching, because the status must drop when the pin drops. Single pulses separate the two polarities. Toggles tell both-edge from single-edge sensing. The coincident clear shows which of set and clear takes priority. Output lines are driven with values that differ from their pins, which exposes any readback that takes the wrong source.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_MODE   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_DIR    = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_ODATA  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_IDATA  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CLR    = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_UNMASK = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_POL    = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_SENSE  = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_BOTH   = 8'h4C;

  typedef struct packed {
    logic irq_mode;
    logic edge_sel;
    logic neg;
    logic both;
  } line_cfg_t;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)      stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d;
      else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_bank_detect.sv
module gpio_bank_detect
  import gpio_bank_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_s,
  input  logic [N-1:0] mode,
  input  logic [N-1:0] edge_sel,
  input  logic [N-1:0] neg,
  input  logic [N-1:0] both,
  input  logic [N-1:0] clr,
  output logic [N-1:0] stat
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pin_s;
  end

  for (genvar i = 0; i < N; i++) begin : g_line
    line_cfg_t c;
    logic      rise, fall, hit, st_q;

    assign c    = '{irq_mode: mode[i], edge_sel: edge_sel[i], neg: neg[i], both: both[i]};
    assign rise = pin_s[i] & ~prev_q[i];
    assign fall = ~pin_s[i] & prev_q[i];
    assign hit  = c.both ? (rise | fall) : (c.neg ? fall : rise);

    always_ff @(posedge clk) begin
      if (!rst_n)           st_q <= 1'b0;
      else if (!c.irq_mode) st_q <= 1'b0;
      else if (!c.edge_sel) st_q <= pin_s[i] ^ c.neg;
      else                  st_q <= (st_q & ~clr[i]) | hit;
    end

    assign stat[i] = st_q;
  end

  // Latched edge status survives any cycle without a clear
  assert_edge_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((stat & $past(stat & mode & edge_sel & ~clr)) == $past(stat & mode & edge_sel & ~clr)));

  // General-mode lines never report status
  assert_general_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((stat & ~$past(mode)) == '0));

  // Same-cycle clear and edge: the set wins
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((stat & $past(mode & edge_sel & clr & (pin_s ^ prev_q) & (both | (pin_s ^ neg))))
               == $past(mode & edge_sel & clr & (pin_s ^ prev_q) & (both | (pin_s ^ neg)))));
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]      wdata,
  input  logic [N-1:0]      stat,
  input  logic [N-1:0]      pin_s,
  output logic [N-1:0]      rdata,
  output logic [N-1:0]      mode,
  output logic [N-1:0]      dir,
  output logic [N-1:0]      odata,
  output logic [N-1:0]      neg,
  output logic [N-1:0]      edge_sel,
  output logic [N-1:0]      both,
  output logic [N-1:0]      mask,
  output logic [N-1:0]      clr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= '0;
      dir      <= '0;
      odata    <= '0;
      neg      <= '0;
      edge_sel <= '0;
      both     <= '0;
      mask     <= '0;
    end else if (wr) begin
      case (addr)
        OFS_MODE:   mode     <= wdata;
        OFS_DIR:    dir      <= wdata;
        OFS_ODATA:  odata    <= wdata;
        OFS_POL:    neg      <= wdata;
        OFS_SENSE:  edge_sel <= wdata;
        OFS_BOTH:   both     <= wdata;
        OFS_MASK:   mask     <= mask & wdata;
        OFS_UNMASK: mask     <= mask | wdata;
        default:    ;
      endcase
    end
  end

  assign clr = (wr && addr == OFS_CLR) ? wdata : '0;

  logic [N-1:0] out_lines;
  assign out_lines = dir & ~mode;

  always_comb begin
    rdata = '0;
    if (rd) begin
      case (addr)
        OFS_MODE:  rdata = mode;
        OFS_DIR:   rdata = dir;
        OFS_ODATA: rdata = odata;
        OFS_IDATA: rdata = (odata & out_lines) | (pin_s & ~out_lines);
        OFS_STAT:  rdata = stat;
        OFS_MASK:  rdata = mask;
        OFS_POL:   rdata = neg;
        OFS_SENSE: rdata = edge_sel;
        OFS_BOTH:  rdata = both;
        default:   rdata = '0;
      endcase
    end
  end

  assert_unmask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == OFS_UNMASK) |=> ((mask & $past(wdata)) == $past(wdata)));

  assert_mask_and_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == OFS_MASK) |=> ((mask & ~$past(wdata)) == '0));

  assert_quiet_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> (rdata == '0));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned N        = 32,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [N-1:0]      reg_wdata,
  output logic [N-1:0]      reg_rdata,
  input  logic [N-1:0]      pin_in,
  output logic [N-1:0]      pin_out,
  output logic [N-1:0]      pin_oe,
  output logic              irq_out
);
  logic [N-1:0] pin_s, stat, mode, dir, odata, neg, edge_sel, both, mask, clr;

  gpio_bank_sync #(.W(N), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
  );

  gpio_bank_regs #(.N(N)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .stat(stat), .pin_s(pin_s), .rdata(reg_rdata),
    .mode(mode), .dir(dir), .odata(odata), .neg(neg), .edge_sel(edge_sel),
    .both(both), .mask(mask), .clr(clr)
  );

  gpio_bank_detect #(.N(N)) u_detect (
    .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .mode(mode), .edge_sel(edge_sel),
    .neg(neg), .both(both), .clr(clr), .stat(stat)
  );

  assign pin_out = odata;
  assign pin_oe  = dir & ~mode;
  assign irq_out = |(stat & mask);

  assert_oe_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & mode) == '0);

  assert_irq_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (mask != '0 && stat != '0));
endmodule

// File: tb/gpio_irq_bank_bench.sv
`timescale 1ns/1ps
module gpio_irq_bank_bench;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic [N-1:0]  reg_wdata = '0, pin_in = '0;
  logic [N-1:0]  reg_rdata, pin_out, pin_oe;
  logic          irq_out;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_irq_bank u_gpio_irq_bank (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  // Behavioural reference model
  logic [N-1:0] m_s1, m_s2, m_prev, m_mode, m_dir, m_out, m_neg, m_sense, m_both, m_mask, m_stat;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_mode <= '0; m_dir <= '0; m_out <= '0;
      m_neg <= '0; m_sense <= '0; m_both <= '0; m_mask <= '0; m_stat <= '0;
    end else begin
      m_s1 <= pin_in; m_s2 <= m_s1; m_prev <= m_s2;
      for (int i = 0; i < N; i++) begin
        bit ev, cl;
        if (m_both[i])     ev = (m_s2[i] != m_prev[i]);
        else if (m_neg[i]) ev = !m_s2[i] && m_prev[i];
        else               ev = m_s2[i] && !m_prev[i];
        cl = reg_wr && reg_addr == 8'h14 && reg_wdata[i];
        if (!m_mode[i])      m_stat[i] <= 1'b0;
        else if (!m_sense[i]) m_stat[i] <= m_s2[i] ^ m_neg[i];
        else                 m_stat[i] <= (m_stat[i] && !cl) || ev;
      end
      if (reg_wr) begin
        case (reg_addr)
          8'h00: m_mode  <= reg_wdata;
          8'h04: m_dir   <= reg_wdata;
          8'h08: m_out   <= reg_wdata;
          8'h20: m_neg   <= reg_wdata;
          8'h24: m_sense <= reg_wdata;
          8'h4C: m_both  <= reg_wdata;
          8'h18: m_mask  <= m_mask & reg_wdata;
          8'h1C: m_mask  <= m_mask | reg_wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [N-1:0] model_rd(input logic [7:0] a);
    logic [N-1:0] ol;
    ol = m_dir & ~m_mode;
    case (a)
      8'h00: return m_mode;
      8'h04: return m_dir;
      8'h08: return m_out;
      8'h0C: return (m_out & ol) | (m_s2 & ~ol);
      8'h10: return m_stat;
      8'h18: return m_mask;
      8'h20: return m_neg;
      8'h24: return m_sense;
      8'h4C: return m_both;
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h0C: return "R3";
      8'h10: return "R5";
      8'h18: return "R8";
      8'h00, 8'h04, 8'h08, 8'h20, 8'h24, 8'h4C: return "R1";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R9 irq_out", {31'b0, irq_out}, {31'b0, |(m_stat & m_mask)});
      check("R2 pin_oe", pin_oe, m_dir & ~m_mode);
      check("R2 pin_out", pin_out, m_out);
      check({tag_of(reg_addr), " rdata"}, reg_rdata, reg_rd ? model_rd(reg_addr) : '0);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [N-1:0] d);
    @(posedge clk); #1;
    reg_rd = 0; reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input string tag);
    @(posedge clk); #1;
    reg_wr = 0; reg_rd = 1; reg_addr = a;
    @(negedge clk);
    check(tag, reg_rdata, model_rd(a));
    @(posedge clk); #1;
    reg_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_pins(input logic [N-1:0] v);
    @(posedge clk); #1;
    pin_in = v;
  endtask

  initial begin
    idle(4);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    check("R1 reset oe", pin_oe, '0);
    check("R1 reset irq", {31'b0, irq_out}, '0);
    rd_chk(8'h00, "R1 mode");
    rd_chk(8'h18, "R1 mask");
    rd_chk(8'h10, "R1 status");

    // General output and readback
    set_pins(32'h1234_56FF);
    wr(8'h04, 32'h0000_00FF);
    wr(8'h08, 32'h0000_00A5);
    idle(3);
    @(negedge clk);
    check("R2 oe constant", pin_oe, 32'h0000_00FF);
    rd_chk(8'h0C, "R3 readback");

    // Level sensing, both polarities
    set_pins(32'h0);
    wr(8'h20, 32'h0000_0200);
    wr(8'h00, 32'h0000_0301);
    wr(8'h1C, 32'h0000_0300);
    idle(3);
    rd_chk(8'h10, "R4 level low");
    @(negedge clk);
    check("R9 irq from level low", {31'b0, irq_out}, 32'h1);
    rd_chk(8'h0C, "R3 readback irq line");
    set_pins(32'h0000_0300);
    idle(4);
    rd_chk(8'h10, "R4 level swap");
    set_pins(32'h0000_0200);
    idle(4);
    rd_chk(8'h10, "R4 level follows");
    @(negedge clk);
    check("R9 irq clear with pin", {31'b0, irq_out}, 32'h0);

    // Edge sensing, rising on 16, falling on 17
    wr(8'h24, 32'h0007_0000);
    wr(8'h20, 32'h0002_0200);
    wr(8'h00, 32'h0007_0301);
    wr(8'h1C, 32'h0007_0000);
    set_pins(32'h0002_0200);
    idle(4);
    wr(8'h14, 32'h0007_0000);
    rd_chk(8'h10, "R5 after clear");
    set_pins(32'h0001_0200);
    idle(4);
    rd_chk(8'h10, "R5 rise and fall");
    set_pins(32'h0000_0200);
    idle(4);
    rd_chk(8'h10, "R5 latched");
    wr(8'h14, 32'h0001_0000);
    rd_chk(8'h10, "R7 partial clear");
    wr(8'h14, 32'h0000_0000);
    rd_chk(8'h10, "R7 zero write");

    // Clear coinciding with a new edge: set wins
    wr(8'h14, 32'h0003_0000);
    set_pins(32'h0001_0200);
    @(posedge clk); #1;
    @(posedge clk); #1;
    reg_wr = 1; reg_addr = 8'h14; reg_wdata = 32'h0001_0000;
    @(posedge clk); #1;
    reg_wr = 0; reg_wdata = '0;
    rd_chk(8'h10, "R7 set wins");

    // Both-edge line 18, polarity set to show it is ignored
    wr(8'h4C, 32'h0004_0000);
    wr(8'h20, 32'h0006_0200);
    wr(8'h14, 32'hFFFF_FFFF);
    set_pins(32'h0005_0200);
    idle(4);
    rd_chk(8'h10, "R6 rising");
    wr(8'h14, 32'h0004_0000);
    set_pins(32'h0001_0200);
    idle(4);
    rd_chk(8'h10, "R6 falling");

    // Masking
    wr(8'h18, 32'hFFFB_FFFF);
    rd_chk(8'h18, "R8 mask write");
    wr(8'h1C, 32'h0000_0001);
    rd_chk(8'h18, "R8 unmask");
    wr(8'h18, 32'h0);
    rd_chk(8'h18, "R8 mask all");
    @(negedge clk);
    check("R9 masked", {31'b0, irq_out}, 32'h0);

    // Read-only and unlisted offsets
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd_chk(8'h10, "R10 status ro");
    rd_chk(8'h0C, "R10 idata ro");
    rd_chk(8'h14, "R10 clr reads 0");
    rd_chk(8'h30, "R10 unlisted");

    idle(3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule